// File: doc/BRIEF.md
# Sign/Magnitude Floating-Point Comparator

This block compares two floating-point operands and returns six relation flags: less, greater, less-or-equal, greater-or-equal, equal and not-equal. The flags feed a branch-on-compare or set-on-compare datapath. The operand width is chosen by a parameter and may be 16, 32 or 64 bits. The exponent and mantissa field widths follow the usual binary interchange layouts for each width.

The ordering relations are cheap. Each operand's raw bit pattern is read as a sign/magnitude integer, and no unordered case is handled. A NaN therefore takes part in ordering like any other pattern, and a positive NaN ranks above positive infinity. Only equality looks for NaN. Equality is false whenever a NaN is present, and not-equal is its complement. Comparing a value with itself for equality is therefore a usable NaN test.

A caller presents both operands together with a valid strobe. The six flags appear in registers one clock later, together with an output valid.

Top module: `sm_fp_compare`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its mantissa field is nonzero. The fields are, for 16/32/64 bits, 5/8/11 exponent bits just below the sign bit (bit FP_W-1) and 10/23/52 mantissa bits at the bottom. An all-ones exponent with a zero mantissa (infinity) is not a NaN.
- R2: For two non-negative operands, less is true exactly when the magnitude (bits FP_W-2..0) of A is below that of B, and greater exactly when it is above.
- R3: A negative operand (sign bit 1) is less than a positive one. Two negative operands order in the reverse of their magnitudes.
- R4: Positive zero and negative zero compare equal, and neither is less or greater than the other.
- R5: Less-or-equal is true when less holds or the operands are order-equal (identical patterns, or both zeros). Greater-or-equal is true when greater holds or the operands are order-equal.
- R6: Equal is true for order-equal operands unless either operand is a NaN, in which case it is false.
- R7: Not-equal is always the inverse of equal, so it is true whenever a NaN is involved.
- R8: A positive NaN compares greater than positive infinity, and positive infinity compares less than it.
- R9: Comparing any operand with itself gives equal false exactly when that operand is a NaN.
- R10: A valid strobe in one cycle raises out_vld in the next cycle with that pair's flags. Without a strobe, out_vld is low in the next cycle and the flags keep their last values.
- R11: While reset (rst_n low) is applied at a clock edge, out_vld and all six flags go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operand pair valid strobe |
| op_a | input | FP_W | Left operand |
| op_b | input | FP_W | Right operand |
| out_vld | output | 1 | Flags valid, one cycle after in_vld |
| res_lt | output | 1 | A less than B |
| res_gt | output | 1 | A greater than B |
| res_le | output | 1 | A less than or equal to B |
| res_ge | output | 1 | A greater than or equal to B |
| res_eq | output | 1 | A equal to B (false with any NaN) |
| res_ne | output | 1 | Inverse of res_eq |

## Verification
Ordinary positive pairs in both orders separate less from greater. Negative/negative and mixed-sign pairs expose any missing reversal of magnitude for negative operands. Signed-zero pairs and identical patterns tell order-equality apart from strict ordering. NaN pairs check that equality alone reacts to NaN while ordering still ranks the NaN above infinity. A pattern with a single mantissa bit set next to plain infinity pins down the NaN field decode. Back-to-back strobes and idle gaps check the one-cycle timing and that the flags hold when no strobe arrives.

// File: rtl/fpcmp_pkg.sv
// Package: shared types and field-width helpers for the floating-point
// comparator. Assumes operand widths of 16, 32 or 64 bits.
package fpcmp_pkg;

    // Six relation flags, kept together as one registered word
    typedef struct packed {
        logic lt;
        logic gt;
        logic le;
        logic ge;
        logic eq;
        logic ne;
    } cmp_flags_t;

    // Exponent field width for a given total operand width
    function automatic int unsigned exp_bits(input int unsigned total_w);
        case (total_w)
            16:      return 5;
            32:      return 8;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
// Module: fpcmp_classify
// Splits one operand into its sign and magnitude and flags NaN and zero.
// Assumes EXP_W + MAN_W + 1 == FP_W, with the sign at the top bit and the
// exponent directly below it.
module fpcmp_classify #(
    parameter int unsigned FP_W  = 32,
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23
) (
    input  logic [FP_W-1:0] op,
    output logic            sgn,
    output logic [FP_W-2:0] mag,
    output logic            is_nan,
    output logic            is_zero
);

    logic exp_ones;
    logic man_nz;

    // Field decode: exponent all ones, mantissa nonzero, magnitude zero
    always_comb begin
        sgn      = op[FP_W-1];
        mag      = op[FP_W-2:0];
        exp_ones = &op[FP_W-2 -: EXP_W];
        man_nz   = |op[MAN_W-1:0];
        is_nan   = exp_ones & man_nz;
        is_zero  = ~|op[FP_W-2:0];
    end

endmodule

// File: rtl/fpcmp_order.sv
// Module: fpcmp_order
// Orders two operands as sign/magnitude integers. Both zeros count as
// equal. NaN is not special here; the caller handles it for equality.
module fpcmp_order #(
    parameter int unsigned MAG_W = 31
) (
    input  logic             sgn_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             zero_a,
    input  logic             sgn_b,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             zero_b,
    output logic             lt,
    output logic             gt,
    output logic             same
);

    logic mag_lo;
    logic mag_hi;

    // Sign/magnitude ordering with the two zeros merged
    always_comb begin
        mag_lo = mag_a < mag_b;
        mag_hi = mag_a > mag_b;
        same   = (zero_a & zero_b) | ((sgn_a == sgn_b) & (mag_a == mag_b));
        if (same) begin
            lt = 1'b0;
            gt = 1'b0;
        end else if (sgn_a != sgn_b) begin
            lt = sgn_a;
            gt = sgn_b;
        end else if (!sgn_a) begin
            lt = mag_lo;
            gt = mag_hi;
        end else begin
            lt = mag_hi;
            gt = mag_lo;
        end
    end

endmodule

// File: rtl/sm_fp_compare.sv
// Module: sm_fp_compare
// Top level of the comparator. Classifies both operands, orders them, and
// registers six relation flags one cycle after in_vld. FP_W must be 16, 32
// or 64. Reset is synchronous and active low.
module sm_fp_compare #(
    parameter int unsigned FP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    output logic            out_vld,
    output logic            res_lt,
    output logic            res_gt,
    output logic            res_le,
    output logic            res_ge,
    output logic            res_eq,
    output logic            res_ne
);
    import fpcmp_pkg::*;

    localparam int unsigned EXP_W = exp_bits(FP_W);
    localparam int unsigned MAN_W = FP_W - 1 - EXP_W;
    localparam int unsigned MAG_W = FP_W - 1;

    logic [FP_W-1:0]  ops     [2];
    logic             sgn     [2];
    logic [MAG_W-1:0] mag     [2];
    logic             nan     [2];
    logic             zro     [2];
    logic             ord_lt;
    logic             ord_gt;
    logic             ord_same;
    logic             any_nan;
    cmp_flags_t       flags_d;
    cmp_flags_t       flags_q;
    logic             vld_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One classifier per operand
    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpcmp_classify #(
            .FP_W (FP_W),
            .EXP_W(EXP_W),
            .MAN_W(MAN_W)
        ) cls_i (
            .op     (ops[gi]),
            .sgn    (sgn[gi]),
            .mag    (mag[gi]),
            .is_nan (nan[gi]),
            .is_zero(zro[gi])
        );
    end

    fpcmp_order #(
        .MAG_W(MAG_W)
    ) ord_i (
        .sgn_a (sgn[0]),
        .mag_a (mag[0]),
        .zero_a(zro[0]),
        .sgn_b (sgn[1]),
        .mag_b (mag[1]),
        .zero_b(zro[1]),
        .lt    (ord_lt),
        .gt    (ord_gt),
        .same  (ord_same)
    );

    // Combine ordering with the NaN check into the six flags
    always_comb begin
        any_nan    = nan[0] | nan[1];
        flags_d.lt = ord_lt;
        flags_d.gt = ord_gt;
        flags_d.le = ord_lt | ord_same;
        flags_d.ge = ord_gt | ord_same;
        flags_d.eq = ord_same & ~any_nan;
        flags_d.ne = ~ord_same | any_nan;
    end

    // Output register: capture flags on a strobe, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            flags_q <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                flags_q <= flags_d;
            end
        end
    end

    assign out_vld = vld_q;
    assign res_lt  = flags_q.lt;
    assign res_gt  = flags_q.gt;
    assign res_le  = flags_q.le;
    assign res_ge  = flags_q.ge;
    assign res_eq  = flags_q.eq;
    assign res_ne  = flags_q.ne;

    // R10: a strobe yields out_vld exactly one cycle later
    p_vld_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_vld_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    // R10: flags hold through idle cycles
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(flags_q));
    // R2: less and greater never together
    p_lt_gt_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !(res_lt && res_gt));
    // R6: a NaN at either classifier forces equal low
    p_nan_not_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (nan[0] || nan[1])) |=> !res_eq);
    // R5: equal implies both inclusive orderings
    p_eq_incl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && res_eq) |-> (res_le && res_ge));
    // R7: not-equal is the inverse of equal
    p_ne_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (res_ne != res_eq));

endmodule

// File: tb/sm_fp_compare_tb_top.sv
// Scoreboard bench for sm_fp_compare at FP_W = 32.
module sm_fp_compare_tb_top;

    typedef struct {
        logic [5:0] flg;
        string      tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_vld;
    logic        res_lt, res_gt, res_le, res_ge, res_eq, res_ne;

    int          n_vec = 0;
    int          n_bad = 0;
    exp_item_t   sb_q[$];
    logic [5:0]  last_flg = '0;
    logic        have_last = 1'b0;

    always #4 clk = ~clk;

    sm_fp_compare #(.FP_W(32)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .op_a   (op_a),
        .op_b   (op_b),
        .out_vld(out_vld),
        .res_lt (res_lt),
        .res_gt (res_gt),
        .res_le (res_le),
        .res_ge (res_ge),
        .res_eq (res_eq),
        .res_ne (res_ne)
    );

    function automatic logic is_nan32(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction

    // Signed integer key: -0 and +0 both map to 0
    function automatic longint key32(logic [31:0] x);
        longint m;
        m = longint'({33'd0, x[30:0]});
        return x[31] ? -m : m;
    endfunction

    // Expected flags {lt,gt,le,ge,eq,ne}
    function automatic logic [5:0] model(logic [31:0] a, logic [31:0] b);
        longint ka, kb;
        logic   e;
        ka = key32(a);
        kb = key32(b);
        e  = (ka == kb) && !is_nan32(a) && !is_nan32(b);
        return {ka < kb, ka > kb, ka <= kb, ka >= kb, e, !e};
    endfunction

    function automatic logic [5:0] dut_flags();
        return {res_lt, res_gt, res_le, res_ge, res_eq, res_ne};
    endfunction

    // Driver: present a pair for one cycle and queue its expectation
    task automatic drive(logic [31:0] a, logic [31:0] b, string tag);
        exp_item_t it;
        @(negedge clk);
        op_a   = a;
        op_b   = b;
        in_vld = 1'b1;
        it.flg = model(a, b);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    // Monitor: compare results away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_vld) begin
                n_vec++;
                if (sb_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R10: unexpected out_vld, actual 1 expected 0");
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    if (dut_flags() !== it.flg) begin
                        n_bad++;
                        $display("FAIL %s: flags actual %b expected %b", it.tag, dut_flags(), it.flg);
                    end
                    last_flg  = it.flg;
                    have_last = 1'b1;
                end
            end else if (rst_n && have_last) begin
                // R10: flags held while idle
                n_vec++;
                if (dut_flags() !== last_flg) begin
                    n_bad++;
                    $display("FAIL R10: held flags actual %b expected %b", dut_flags(), last_flg);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        n_vec++;
        if ({out_vld, dut_flags()} !== 7'd0) begin
            n_bad++;
            $display("FAIL R11: actual %b expected 0000000", {out_vld, dut_flags()});
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        drive(32'h3F800000, 32'h40000000, "R2");   // 1 vs 2
        drive(32'h40000000, 32'h3F800000, "R2");   // 2 vs 1
        drive(32'h00000001, 32'h7F7FFFFF, "R2");   // denormal vs max
        drive(32'hBF800000, 32'hC0000000, "R3");   // -1 vs -2
        drive(32'hC0000000, 32'h3F800000, "R3");   // -2 vs 1
        drive(32'h3F800000, 32'hBF800000, "R3");   // 1 vs -1
        idle(2);
        drive(32'h00000000, 32'h80000000, "R4");
        drive(32'h80000000, 32'h00000000, "R4");
        drive(32'h40000000, 32'h40000000, "R5");
        drive(32'hC0000000, 32'hC0000000, "R5");
        drive(32'h7FC00000, 32'h3F800000, "R6");
        drive(32'h3F800000, 32'hFFC00000, "R6");
        drive(32'h7FC00000, 32'h7FC00000, "R7");
        idle(1);
        drive(32'h7FC00000, 32'h7F800000, "R8");
        drive(32'h7F800000, 32'h7FC00000, "R8");
        drive(32'hFFC00000, 32'hFFC00000, "R9");
        drive(32'h7F800000, 32'h7F800000, "R9");
        drive(32'h3F800000, 32'h3F800000, "R9");
        drive(32'h7F800001, 32'h7F800001, "R1");   // one mantissa bit: NaN
        drive(32'hFF800000, 32'hFF800000, "R1");   // -inf: not NaN
        drive(32'h7F7FFFFF, 32'h7F7FFFFF, "R1");
        idle(4);
        drive(32'h3F800000, 32'h00000000, "R10");
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule